// File: doc/BRIEF.md
# Microwire Serial Slave Port

This block is a synchronous serial slave for the Microwire frame format. An external master drives a serial clock, an active-low frame strobe and a receive data line. The slave drives a transmit data line back. All three inputs are oversampled on the system clock through a synchroniser, and clock edges are found from the synchronised samples. Each frame opens with a fixed 8-bit control word from the master. The slave then answers with a data word of 4 to 16 bits. The answer length comes from a configuration input, and both words travel most significant bit first.

The received control byte is presented on a parallel output together with a single-cycle strobe. The response word is taken from a parallel input at that same moment. The frame strobe may stay low across several exchanges, so control and data phases can follow one another while the serial clock keeps running. The port also measures the serial clock period. From it, the port checks that the frame strobe met its setup and hold margins around the first sampling edge, and flags any breach. A frame strobe that returns high partway through an exchange abandons that exchange and raises a one-cycle abort indication.

Top module: `mwire_slave`

## Requirements
- R1: After the synchronised frame strobe falls, the first rising serial-clock edge that follows samples the first control bit. The next seven rising edges sample the rest. Bits arrive most significant first.
- R2: When the eighth control bit is captured, `cmd_valid_o` pulses for exactly one system-clock cycle, with the assembled byte on `cmd_o`. No other event produces that pulse.
- R3: The response has N bits. Bit N-1 of `resp_data_i` is driven first and bit 0 last. A new bit appears after each falling serial-clock edge, starting with the falling edge that follows the eighth control rising edge, so every bit is stable at the rising edge where the master samples it. N and the word are latched when the eighth control bit is captured.
- R4: A length request below 4 gives a 4-bit response. A request above 16 gives a 16-bit response. Values from 4 to 16 are used as given.
- R5: `sdo_o` is low whenever no data phase is in progress: while idle, during a control phase, and once the frame strobe is high.
- R6: If the frame strobe stays low after a data phase, the rising edge after the one that sampled the last data bit begins a new 8-bit control phase.
- R7: Let P be the system-clock count between the two most recent rising serial-clock edges. `setup_err_o` is set when the count from the frame fall to the first sampling edge is less than 2·P. No check is made until two rising edges have been seen since reset. The flag stays set until the next frame fall clears it.
- R8: At each frame fall, `hold_err_o` is loaded with whether fewer than P system-clock cycles have passed since the last rising serial-clock edge. P is the measured period of R7, and the check needs the same two rising edges. The flag holds its value until the next frame fall.
- R9: If the frame strobe returns high after at least one bit of an exchange has moved but before that exchange completes, `abort_o` pulses for one cycle. No control byte is reported for an incomplete control phase, `sdo_o` goes low, and the next frame starts again from its first control bit.
- R10: If the frame strobe returns high when no bit of a new exchange has moved, the port goes idle without an abort pulse. This covers the point just after a completed data phase.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master, may run continuously |
| frame_n_i | input | 1 | Active-low frame strobe from the master |
| sdi_i | input | 1 | Serial data from master to slave |
| sdo_o | output | 1 | Serial data from slave to master |
| resp_len_i | input | 5 | Requested response length in bits |
| resp_data_i | input | 16 | Response word, right-aligned |
| cmd_o | output | 8 | Last received control byte |
| cmd_valid_o | output | 1 | One-cycle strobe when `cmd_o` is updated |
| setup_err_o | output | 1 | Sticky frame-setup violation flag |
| hold_err_o | output | 1 | Sticky frame-hold violation flag |
| abort_o | output | 1 | One-cycle strobe when an exchange is abandoned |

## Verification
The bench covers response lengths at both ends of the legal range and beyond them on both sides. A wrong clamp or a wrong alignment shift would put the wrong bits, or too many of them, on the line. It runs two exchanges under one unbroken frame strobe, where a design that returned to idle or lost count at the end of a data phase would miss or corrupt the second control byte. It drops the frame strobe both too close to the first sampling edge and too soon after a preceding clock edge. A port that measured in the wrong unit, or never cleared its flags, would report the wrong flag or keep a stale one. It abandons frames in the control phase and again in the data phase, where a design that failed to reset its bit counters would misread the next frame or leave the data line high.

// File: rtl/mwire_pkg.sv
package mwire_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_DATA = 2'd2
   } phase_t;

   typedef struct packed {
      logic rise;
      logic fall;
   } edges_t;

endpackage

// File: rtl/mwire_sync.sv
module mwire_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mwire_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [WIDTH-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stg[i-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/mwire_timing.sv
module mwire_timing #(
   parameter int CNT_W         = 16,
   parameter int SETUP_PERIODS = 2,
   parameter int HOLD_PERIODS  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_rise,
   input  logic frm_fall,
   input  logic first_edge,
   output logic setup_err,
   output logic hold_err
);

   localparam int W2 = CNT_W + 2;

   if (SETUP_PERIODS < 1 || SETUP_PERIODS > 3) begin : g_bad_setup
      $error("mwire_timing: SETUP_PERIODS must lie in 1..3");
   end
   if (HOLD_PERIODS < 1 || HOLD_PERIODS > 3) begin : g_bad_hold
      $error("mwire_timing: HOLD_PERIODS must lie in 1..3");
   end

   logic [CNT_W-1:0] since_rise;
   logic [CNT_W-1:0] since_fall;
   logic [CNT_W-1:0] period;
   logic [1:0]       rises_seen;
   logic             per_ok;
   logic [W2-1:0]    rise_gap, fall_gap, setup_need, hold_need;

   always_comb begin
      per_ok     = (rises_seen == 2'd2);
      rise_gap   = W2'(since_rise) + W2'(1);
      fall_gap   = W2'(since_fall) + W2'(1);
      setup_need = W2'(period) * W2'(SETUP_PERIODS);
      hold_need  = W2'(period) * W2'(HOLD_PERIODS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rise <= '0;
         since_fall <= '0;
         period     <= '0;
         rises_seen <= '0;
         setup_err  <= 1'b0;
         hold_err   <= 1'b0;
      end else begin
         if (sck_rise) begin
            since_rise <= '0;
            period     <= (since_rise == '1) ? since_rise : since_rise + 1'b1;
            if (!per_ok) rises_seen <= rises_seen + 2'd1;
         end else if (since_rise != '1) begin
            since_rise <= since_rise + 1'b1;
         end

         if (frm_fall)                since_fall <= '0;
         else if (since_fall != '1)   since_fall <= since_fall + 1'b1;

         if (frm_fall) begin
            setup_err <= 1'b0;
            hold_err  <= per_ok && (rise_gap < hold_need);
         end else if (first_edge && per_ok && (fall_gap < setup_need)) begin
            setup_err <= 1'b1;
         end
      end
   end

   AST_SETUP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(setup_err) |-> $past(first_edge)); // R7
   AST_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_err) |-> $past(frm_fall)); // R8

endmodule

// File: rtl/mwire_xfer.sv
module mwire_xfer
   import mwire_pkg::*;
#(
   parameter int CMD_BITS = 8,
   parameter int DATA_MAX = 16,
   parameter int DATA_MIN = 4,
   parameter int LEN_W    = $clog2(DATA_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  edges_t              sck_e,
   input  edges_t              frm_e,
   input  logic                rxd,
   input  logic [LEN_W-1:0]    resp_len,
   input  logic [DATA_MAX-1:0] resp_word,
   output logic [CMD_BITS-1:0] cmd_byte,
   output logic                cmd_valid,
   output logic                txd,
   output logic                abort,
   output logic                first_edge
);

   localparam int CB_W = $clog2(CMD_BITS);

   phase_t              phase;
   logic [CMD_BITS-1:0] cmd_sr;
   logic [CB_W-1:0]     bit_cnt;
   logic [DATA_MAX-1:0] tx_sr;
   logic [LEN_W-1:0]    tx_cnt;
   logic [LEN_W-1:0]    tx_len;
   logic                first_pend;
   logic [LEN_W-1:0]    len_c;
   logic [DATA_MAX-1:0] aligned;
   logic [CMD_BITS-1:0] cmd_next;

   if (DATA_MIN == DATA_MAX) begin : g_fixed_len
      assign len_c = LEN_W'(DATA_MAX);
   end else begin : g_clamp_len
      always_comb begin
         if (resp_len < LEN_W'(DATA_MIN))      len_c = LEN_W'(DATA_MIN);
         else if (resp_len > LEN_W'(DATA_MAX)) len_c = LEN_W'(DATA_MAX);
         else                                  len_c = resp_len;
      end
   end

   assign aligned    = resp_word << (LEN_W'(DATA_MAX) - len_c);
   assign cmd_next   = {cmd_sr[CMD_BITS-2:0], rxd};
   assign first_edge = (phase == PH_CMD) && first_pend && sck_e.rise && !frm_e.rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cmd_sr     <= '0;
         bit_cnt    <= '0;
         tx_sr      <= '0;
         tx_cnt     <= '0;
         tx_len     <= LEN_W'(DATA_MIN);
         first_pend <= 1'b0;
         cmd_byte   <= '0;
         cmd_valid  <= 1'b0;
         txd        <= 1'b0;
         abort      <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         abort     <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               txd <= 1'b0;
               if (frm_e.fall) begin
                  phase      <= PH_CMD;
                  bit_cnt    <= '0;
                  first_pend <= 1'b1;
               end
            end
            PH_CMD: begin
               if (frm_e.rise) begin
                  phase      <= PH_IDLE;
                  abort      <= (bit_cnt != '0);
                  bit_cnt    <= '0;
                  first_pend <= 1'b0;
               end else if (sck_e.rise) begin
                  first_pend <= 1'b0;
                  cmd_sr     <= cmd_next;
                  if (bit_cnt == CB_W'(CMD_BITS - 1)) begin
                     cmd_byte  <= cmd_next;
                     cmd_valid <= 1'b1;
                     tx_sr     <= aligned;
                     tx_len    <= len_c;
                     tx_cnt    <= '0;
                     bit_cnt   <= '0;
                     phase     <= PH_DATA;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            PH_DATA: begin
               if (frm_e.rise) begin
                  phase <= PH_IDLE;
                  abort <= 1'b1;
                  txd   <= 1'b0;
               end else if (sck_e.fall && tx_cnt != tx_len) begin
                  txd    <= tx_sr[DATA_MAX-1];
                  tx_sr  <= tx_sr << 1;
                  tx_cnt <= tx_cnt + 1'b1;
               end else if (sck_e.rise && tx_cnt == tx_len) begin
                  phase   <= PH_CMD;
                  bit_cnt <= '0;
                  txd     <= 1'b0;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R2
   AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(sck_e.rise)); // R2
   AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (tx_len >= LEN_W'(DATA_MIN) && tx_len <= LEN_W'(DATA_MAX))); // R4
   AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && $past(phase) == PH_DATA && txd != $past(txd)) |-> $past(sck_e.fall)); // R3
   AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_DATA) |-> !txd); // R5
   AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !abort); // R9

endmodule

// File: rtl/mwire_slave.sv
module mwire_slave
   import mwire_pkg::*;
#(
   parameter int CMD_BITS      = 8,
   parameter int DATA_MAX      = 16,
   parameter int DATA_MIN      = 4,
   parameter int SYNC_STAGES   = 2,
   parameter int CNT_W         = 16,
   parameter int SETUP_PERIODS = 2,
   parameter int HOLD_PERIODS  = 1,
   localparam int LEN_W        = $clog2(DATA_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sck_i,
   input  logic                frame_n_i,
   input  logic                sdi_i,
   output logic                sdo_o,
   input  logic [LEN_W-1:0]    resp_len_i,
   input  logic [DATA_MAX-1:0] resp_data_i,
   output logic [CMD_BITS-1:0] cmd_o,
   output logic                cmd_valid_o,
   output logic                setup_err_o,
   output logic                hold_err_o,
   output logic                abort_o
);

   if (CMD_BITS < 2) begin : g_bad_cmd
      $error("mwire_slave: CMD_BITS must be at least 2");
   end
   if (DATA_MIN < 1 || DATA_MIN > DATA_MAX) begin : g_bad_len
      $error("mwire_slave: need 1 <= DATA_MIN <= DATA_MAX");
   end

   logic [2:0] sync_q;
   logic       s_sck, s_frm, s_sdi;
   logic       sck_q, frm_q;
   edges_t     sck_e, frm_e;
   logic       first_edge;

   mwire_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sdi_i, frame_n_i, sck_i}),
      .q     (sync_q)
   );

   assign s_sck = sync_q[0];
   assign s_frm = sync_q[1];
   assign s_sdi = sync_q[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         frm_q <= 1'b1;
      end else begin
         sck_q <= s_sck;
         frm_q <= s_frm;
      end
   end

   assign sck_e.rise = s_sck & ~sck_q;
   assign sck_e.fall = ~s_sck & sck_q;
   assign frm_e.rise = s_frm & ~frm_q;
   assign frm_e.fall = ~s_frm & frm_q;

   mwire_xfer #(
      .CMD_BITS (CMD_BITS),
      .DATA_MAX (DATA_MAX),
      .DATA_MIN (DATA_MIN),
      .LEN_W    (LEN_W)
   ) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_e      (sck_e),
      .frm_e      (frm_e),
      .rxd        (s_sdi),
      .resp_len   (resp_len_i),
      .resp_word  (resp_data_i),
      .cmd_byte   (cmd_o),
      .cmd_valid  (cmd_valid_o),
      .txd        (sdo_o),
      .abort      (abort_o),
      .first_edge (first_edge)
   );

   mwire_timing #(
      .CNT_W         (CNT_W),
      .SETUP_PERIODS (SETUP_PERIODS),
      .HOLD_PERIODS  (HOLD_PERIODS)
   ) u_timing (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_rise   (sck_e.rise),
      .frm_fall   (frm_e.fall),
      .first_edge (first_edge),
      .setup_err  (setup_err_o),
      .hold_err   (hold_err_o)
   );

   AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !cmd_valid_o); // R9
   AST_FRAME_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (s_frm && $past(s_frm)) |-> !sdo_o); // R5

endmodule

// File: tb/mwire_slave_bench.sv
module mwire_slave_bench;

   localparam int H = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        frame_n = 1'b1;
   logic        sdi = 1'b0;
   logic [4:0]  len_cfg = 5'd8;
   logic [15:0] word = 16'h0;
   logic        sdo;
   logic [7:0]  cmd;
   logic        cmd_valid, setup_err, hold_err, abort;

   int   n_chk = 0;
   int   n_fail = 0;
   int   abort_seen = 0;
   int   hi_run = 0;
   bit   done = 1'b0;
   logic [7:0] cmd_q[$];

   always #4 clk = ~clk;

   mwire_slave u_mwire_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .sck_i       (sck),
      .frame_n_i   (frame_n),
      .sdi_i       (sdi),
      .sdo_o       (sdo),
      .resp_len_i  (len_cfg),
      .resp_data_i (word),
      .cmd_o       (cmd),
      .cmd_valid_o (cmd_valid),
      .setup_err_o (setup_err),
      .hold_err_o  (hold_err),
      .abort_o     (abort)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock reference: with the strobe high for a while, the line is quiet (R5)
   always @(negedge clk) begin
      if (cmd_valid) cmd_q.push_back(cmd);
      if (abort) abort_seen++;
      if (rst_n && frame_n) hi_run++;
      else                  hi_run = 0;
      if (hi_run >= 6) chk(sdo == 1'b0, "R5 line low while frame high", int'(sdo), 0);
   end

   task automatic clk_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic b, output logic got);
      sdi = b;
      got = sdo;
      sck = 1'b1;
      clk_n(H);
      sck = 1'b0;
      clk_n(H);
   endtask

   task automatic send_cmd(input logic [7:0] c);
      logic g;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(c[i], g);
         chk(g == 1'b0, "R5 line low in control phase", int'(g), 0);
      end
   endtask

   task automatic recv_data(input logic [15:0] w, input int n, input string tag);
      logic g;
      for (int i = n - 1; i >= 0; i--) begin
         bit_cycle(1'b0, g);
         chk(g == w[i], tag, int'(g), int'(w[i]));
      end
   endtask

   task automatic expect_cmd(input logic [7:0] c);
      clk_n(2);
      chk(cmd_q.size() == 1, "R2 one strobe per control word", cmd_q.size(), 1);
      if (cmd_q.size() > 0) chk(cmd_q[0] == c, "R1 control byte", int'(cmd_q[0]), int'(c));
      cmd_q.delete();
   endtask

   task automatic frame(input logic [7:0] c, input logic [4:0] lc, input logic [15:0] w,
                        input int n, input int gap, input string tag);
      len_cfg = lc;
      word = w;
      frame_n = 1'b0;
      clk_n(gap);
      send_cmd(c);
      recv_data(w, n, tag);
      frame_n = 1'b1;
      clk_n(10);
      expect_cmd(c);
   endtask

   initial begin
      int ab;
      logic g;
      clk_n(3);
      rst_n = 1'b1;
      clk_n(3);
      chk({sdo, cmd_valid, setup_err, hold_err, abort} == 5'b0, "R11 reset outputs",
          int'({sdo, cmd_valid, setup_err, hold_err, abort}), 0);
      chk(cmd == 8'h00, "R11 reset byte", int'(cmd), 0);

      frame(8'hA5, 5'd8, 16'h00C3, 8, 30, "R3 8-bit response");
      frame(8'h3C, 5'd16, 16'hBEEF, 16, 30, "R3 16-bit response");
      frame(8'h81, 5'd4, 16'hFFF9, 4, 30, "R3 4-bit response");
      frame(8'h5A, 5'd2, 16'h0006, 4, 30, "R4 short request clamped to 4");
      frame(8'hE7, 5'd31, 16'h1234, 16, 30, "R4 long request clamped to 16");
      chk(setup_err == 1'b0, "R7 no false setup flag", int'(setup_err), 0);
      chk(hold_err == 1'b0, "R8 no false hold flag", int'(hold_err), 0);
      chk(abort_seen == 0, "R10 clean ends give no abort", abort_seen, 0);

      // continuous exchanges under one strobe
      len_cfg = 5'd6;
      word = 16'h002D;
      frame_n = 1'b0;
      clk_n(30);
      send_cmd(8'hC1);
      recv_data(16'h002D, 6, "R6 first data in run");
      len_cfg = 5'd10;
      word = 16'h0299;
      send_cmd(8'h4E);
      recv_data(16'h0299, 10, "R6 second data in run");
      frame_n = 1'b1;
      clk_n(10);
      chk(cmd_q.size() == 2, "R6 two control bytes", cmd_q.size(), 2);
      if (cmd_q.size() == 2) begin
         chk(cmd_q[0] == 8'hC1, "R6 first byte", int'(cmd_q[0]), 'hC1);
         chk(cmd_q[1] == 8'h4E, "R6 second byte", int'(cmd_q[1]), 'h4E);
      end
      cmd_q.delete();
      chk(abort_seen == 0, "R10 run end gives no abort", abort_seen, 0);

      // setup breach: strobe falls 10 cycles before first edge, period 12
      frame(8'h0F, 5'd8, 16'h00AA, 8, 10, "R7 transfer despite setup breach");
      chk(setup_err == 1'b1, "R7 setup flag set", int'(setup_err), 1);
      chk(hold_err == 1'b0, "R8 hold clean on setup breach", int'(hold_err), 0);
      frame(8'hF0, 5'd8, 16'h0055, 8, 30, "R3 data after setup breach");
      chk(setup_err == 1'b0, "R7 setup flag cleared by next fall", int'(setup_err), 0);

      // hold breach: strobe falls 3 cycles after a clock rise
      len_cfg = 5'd5;
      word = 16'h0015;
      sck = 1'b1;
      clk_n(3);
      frame_n = 1'b0;
      clk_n(H - 3);
      sck = 1'b0;
      clk_n(80);
      send_cmd(8'h99);
      recv_data(16'h0015, 5, "R3 data in hold-breach frame");
      frame_n = 1'b1;
      clk_n(10);
      expect_cmd(8'h99);
      chk(hold_err == 1'b1, "R8 hold flag set", int'(hold_err), 1);
      chk(setup_err == 1'b0, "R7 no setup flag on late edge", int'(setup_err), 0);
      frame(8'h24, 5'd8, 16'h00F1, 8, 30, "R3 data after hold breach");
      chk(hold_err == 1'b0, "R8 hold flag cleared", int'(hold_err), 0);

      // abort inside control phase
      ab = abort_seen;
      frame_n = 1'b0;
      clk_n(30);
      for (int i = 0; i < 3; i++) bit_cycle(1'b1, g);
      frame_n = 1'b1;
      clk_n(10);
      chk(abort_seen == ab + 1, "R9 abort in control phase", abort_seen, ab + 1);
      chk(cmd_q.size() == 0, "R9 no byte from partial control", cmd_q.size(), 0);
      frame(8'h6B, 5'd7, 16'h0053, 7, 30, "R9 clean restart after abort");

      // abort inside data phase
      ab = abort_seen;
      len_cfg = 5'd16;
      word = 16'hFFFF;
      frame_n = 1'b0;
      clk_n(30);
      send_cmd(8'hD2);
      recv_data(16'hFFFF, 2, "R3 leading bits before abort");
      frame_n = 1'b1;
      clk_n(10);
      chk(abort_seen == ab + 1, "R9 abort in data phase", abort_seen, ab + 1);
      chk(sdo == 1'b0, "R9 line low after abort", int'(sdo), 0);
      expect_cmd(8'hD2);
      frame(8'h17, 5'd9, 16'h0135, 9, 30, "R9 frame after data abort");
      chk(abort_seen == ab + 1, "R10 no extra abort", abort_seen, ab + 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule